// File: doc/BRIEF.md
# Carry-Chain Equality Comparator

This block decides whether two N-bit values are equal, or whether one N-bit value equals a constant fixed at elaboration. It works purely combinationally. The operands are cut into chunks, and each chunk produces one match bit. The match bits then steer a ripple of carry cells. The ripple starts with a carry of 1, and each cell passes the carry on only when its own chunk matches. The carry that leaves the last cell is therefore the equality result. This is the structure that maps well onto the dedicated carry logic of programmable fabrics, where K-input lookups sit in front of each carry cell.

The chunk width follows from the lookup size K. When both operands are signals, one lookup has to hold bits of both, so each chunk covers K/2 bits of each operand. When the second operand is a constant, the constant lives inside the lookup, so each chunk covers K bits of the signal. If N is not a multiple of the chunk width, the last chunk is partial: only the bits that exist are compared, and the missing positions count as matching. An elaboration-time flag inverts the final carry, so the same structure reports inequality.

Top module: `cceq_compare`

## Requirements
- R1: With CONST_MODE=0 and INVERT=0, `result` is 1 exactly when `opnd_a` equals `opnd_b` across all N bits.
- R2: With CONST_MODE=1 and INVERT=0, `result` is 1 exactly when `opnd_a` equals the parameter CONST_VAL.
- R3: With CONST_MODE=1, the value on `opnd_b` has no effect on `result`.
- R4: With INVERT=1, `result` is the complement of the value R1 or R2 would give for the same inputs, so a 1 means "not equal".
- R5: Operands that differ only in bit 0 are reported as not equal.
- R6: Operands that differ only in bit N-1 are reported as not equal.
- R7: When N is not a multiple of the chunk width (K/2 for two signals, K for a constant), a difference inside the trailing partial chunk is detected, and equal operands are still reported equal.
- R8: The carry into the first cell is 1, and a chunk that does not match forces the carry out of its cell to 0. The final carry is therefore 1 only when every chunk matches, and a single differing bit at any position gives "not equal".

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | N | Value under test |
| opnd_b | input | N | Second value, compared against `opnd_a` when CONST_MODE=0; unused when CONST_MODE=1 |
| result | output | 1 | Final carry of the chain, inverted when INVERT=1 |

## Verification
The bench builds four copies side by side, all with N=13. The first compares two signals with K=6, which gives 3-bit chunks. The second compares against a constant with K=4, which gives 4-bit chunks. The third compares two signals with K=8 and INVERT=1. The fourth compares against a constant with K=2 and INVERT=1, which gives 2-bit chunks and seven carry cells. With 13 bits, every copy ends in a one-bit partial chunk at bit 12, so the MSB and partial-chunk cases fall on the same position while the chunk boundaries inside differ. A single-bit difference is walked through every position, and random pairs are mixed with exactly equal pairs and with values equal to the constant, so that every copy sees both outcomes.

// File: rtl/cceq_pkg.sv
package cceq_pkg;

    // Bits of each operand handled by one lookup in front of a carry cell.
    function automatic int unsigned chunk_width(input int unsigned k, input bit const_mode);
        return const_mode ? k : (k / 2);
    endfunction

    // Number of carry cells needed to cover n bits.
    function automatic int unsigned chunk_count(input int unsigned n, input int unsigned w);
        return (n + w - 1) / w;
    endfunction

    // Width after padding up to a whole number of chunks.
    function automatic int unsigned padded_width(input int unsigned n, input int unsigned w);
        return chunk_count(n, w) * w;
    endfunction

    // Signals at the boundary of one carry cell.
    typedef struct packed {
        logic prop;
        logic cin;
    } cell_in_t;

endpackage

// File: rtl/cceq_chunk_match.sv
module cceq_chunk_match #(
    parameter int unsigned W           = 3,
    parameter bit          CONST_MODE  = 1'b0,
    parameter logic [W-1:0] CONST_CHUNK = '0
) (
    input  logic [W-1:0] a_seg,
    input  logic [W-1:0] b_seg,
    output logic         hit
);

    generate
        if (CONST_MODE) begin : g_const
            // The constant is folded in: W signal bits against fixed values.
            logic [W-1:0] same;
            always_comb begin
                same = a_seg ~^ CONST_CHUNK;
                hit  = &same;
            end
            logic unused_b;
            assign unused_b = ^b_seg;
        end else begin : g_var
            logic [W-1:0] same;
            always_comb begin
                same = a_seg ~^ b_seg;
                hit  = &same;
            end
        end
    endgenerate

endmodule

// File: rtl/cceq_carry_cell.sv
module cceq_carry_cell (
    input  cceq_pkg::cell_in_t cell_in,
    output logic               cout
);

    // Propagate when the chunk matches, otherwise kill (generate term is 0).
    always_comb begin
        cout = cell_in.prop ? cell_in.cin : 1'b0;
    end

endmodule

// File: rtl/cceq_carry_chain.sv
module cceq_carry_chain #(
    parameter int unsigned NST = 4
) (
    input  logic [NST-1:0] prop,
    output logic [NST:0]   carry
);

    assign carry[0] = 1'b1;

    generate
        for (genvar s = 0; s < NST; s++) begin : g_cell
            cceq_pkg::cell_in_t cin_s;
            assign cin_s.prop = prop[s];
            assign cin_s.cin  = carry[s];
            cceq_carry_cell u_cell (
                .cell_in (cin_s),
                .cout    (carry[s+1])
            );
        end
    endgenerate

endmodule

// File: rtl/cceq_compare.sv
module cceq_compare #(
    parameter int unsigned  N          = 16,
    parameter int unsigned  K          = 6,
    parameter bit           CONST_MODE = 1'b0,
    parameter logic [N-1:0] CONST_VAL  = '0,
    parameter bit           INVERT     = 1'b0
) (
    input  logic [N-1:0] opnd_a,
    input  logic [N-1:0] opnd_b,
    output logic         result
);

    localparam int unsigned CW  = cceq_pkg::chunk_width(K, CONST_MODE);
    localparam int unsigned NCH = cceq_pkg::chunk_count(N, CW);
    localparam int unsigned PW  = cceq_pkg::padded_width(N, CW);
    localparam logic [PW-1:0] K_PAD = PW'(CONST_VAL);

    logic [PW-1:0]  a_pad;
    logic [PW-1:0]  b_pad;
    logic [NCH-1:0] chunk_hit;
    logic [NCH:0]   chain_carry;

    // Absent bits of the last chunk are zero on both sides, so they match.
    always_comb begin
        a_pad        = '0;
        a_pad[N-1:0] = opnd_a;
        b_pad        = '0;
        b_pad[N-1:0] = opnd_b;
    end

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_chunk
            cceq_chunk_match #(
                .W           (CW),
                .CONST_MODE  (CONST_MODE),
                .CONST_CHUNK (K_PAD[c*CW +: CW])
            ) u_match (
                .a_seg (a_pad[c*CW +: CW]),
                .b_seg (b_pad[c*CW +: CW]),
                .hit   (chunk_hit[c])
            );
        end
    endgenerate

    cceq_carry_chain #(
        .NST (NCH)
    ) u_chain (
        .prop  (chunk_hit),
        .carry (chain_carry)
    );

    generate
        if (INVERT) begin : g_ne
            assign result = ~chain_carry[NCH];
        end else begin : g_eq
            assign result = chain_carry[NCH];
        end
    endgenerate

endmodule

// File: rtl/cceq_compare_chk.sv
module cceq_compare_chk #(
    parameter int unsigned  N          = 16,
    parameter int unsigned  NCH        = 6,
    parameter bit           CONST_MODE = 1'b0,
    parameter logic [N-1:0] CONST_VAL  = '0,
    parameter bit           INVERT     = 1'b0
) (
    input logic [N-1:0]   opnd_a,
    input logic [N-1:0]   opnd_b,
    input logic [NCH-1:0] hits,
    input logic [NCH:0]   carry,
    input logic           result
);

    always_comb begin
        if (!$isunknown({hits, carry})) begin
            AST_CHAIN_ALL: assert (carry[NCH] == (&hits)); // R8
        end
    end

    generate
        for (genvar s = 0; s < NCH; s++) begin : g_kill
            always_comb begin
                if (!$isunknown({hits[s], carry[s+1]}) && !hits[s]) begin
                    AST_CELL_KILL: assert (!carry[s+1]); // R8
                end
            end
        end

        if (CONST_MODE) begin : g_const
            always_comb begin
                if (!$isunknown({opnd_a, result})) begin
                    AST_CONST_MATCH: assert (result == ((opnd_a == CONST_VAL) ^ INVERT)); // R2
                end
            end
        end else begin : g_var
            always_comb begin
                if (!$isunknown({opnd_a, opnd_b, result})) begin
                    AST_VAR_MATCH: assert (result == ((opnd_a == opnd_b) ^ INVERT)); // R1
                end
            end
        end

        if (INVERT) begin : g_inv
            always_comb begin
                if (!$isunknown({result, carry[NCH]})) begin
                    AST_INVERT_OUT: assert (result != carry[NCH]); // R4
                end
            end
        end
    endgenerate

endmodule

bind cceq_compare cceq_compare_chk #(
    .N          (N),
    .NCH        (NCH),
    .CONST_MODE (CONST_MODE),
    .CONST_VAL  (CONST_VAL),
    .INVERT     (INVERT)
) u_chk (
    .opnd_a (opnd_a),
    .opnd_b (opnd_b),
    .hits   (chunk_hit),
    .carry  (chain_carry),
    .result (result)
);

// File: tb/test_cceq_compare.sv
`timescale 1ns/1ps
module test_cceq_compare;

    localparam int unsigned  N  = 13;
    localparam logic [N-1:0] KV = 13'h0B5D;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic [N-1:0] a = '0;
    logic [N-1:0] b = '0;
    logic r_eq, r_keq, r_ne, r_kne;

    cceq_compare #(.N(N), .K(6), .CONST_MODE(1'b0), .CONST_VAL('0), .INVERT(1'b0))
        i_cceq_compare (.opnd_a(a), .opnd_b(b), .result(r_eq));
    cceq_compare #(.N(N), .K(4), .CONST_MODE(1'b1), .CONST_VAL(KV), .INVERT(1'b0))
        i_cceq_compare_k4 (.opnd_a(a), .opnd_b(b), .result(r_keq));
    cceq_compare #(.N(N), .K(8), .CONST_MODE(1'b0), .CONST_VAL('0), .INVERT(1'b1))
        i_cceq_compare_n8 (.opnd_a(a), .opnd_b(b), .result(r_ne));
    cceq_compare #(.N(N), .K(2), .CONST_MODE(1'b1), .CONST_VAL(KV), .INVERT(1'b1))
        i_cceq_compare_k2 (.opnd_a(a), .opnd_b(b), .result(r_kne));

    typedef struct {
        logic  e_eq;
        logic  e_keq;
        logic  e_ne;
        logic  e_kne;
        string req;
    } item_t;

    item_t q[$];
    int n_run  = 0;
    int n_fail = 0;
    bit ended  = 1'b0;

    function automatic void chk(input logic act, input logic exp,
                                input string req, input string what);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endfunction

    // Driver: apply operands, push the values the requirements predict.
    task automatic drive(input logic [N-1:0] av, input logic [N-1:0] bv, input string req);
        item_t it;
        @(posedge clk);
        a = av;
        b = bv;
        it.e_eq  = (av == bv);
        it.e_keq = (av == KV);
        it.e_ne  = (av != bv);
        it.e_kne = (av != KV);
        it.req   = req;
        q.push_back(it);
    endtask

    // Monitor: combinational outputs are settled by the falling edge.
    always @(negedge clk) begin
        item_t it;
        if (!rst && q.size() > 0) begin
            it = q.pop_front();
            chk(r_eq,  it.e_eq,  it.req, "signal K6");
            chk(r_keq, it.e_keq, it.req, "const K4");
            chk(r_ne,  it.e_ne,  $sformatf("R4(%s)", it.req), "signal K8 inverted");
            chk(r_kne, it.e_kne, $sformatf("R4(%s)", it.req), "const K2 inverted");
        end
    end

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        logic [N-1:0] x;
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // R1: equal and unequal pairs, including all-zero after reset.
        drive('0, '0, "R1");
        drive('1, '1, "R1");
        drive(13'h0AAA, 13'h1555, "R1");

        // R2: against the constant.
        drive(KV, KV, "R2");
        drive(KV ^ 13'h0010, KV, "R2");

        // R3: opnd_b is changed while opnd_a holds the constant.
        drive(KV, 13'h0000, "R3");
        drive(KV, 13'h1FFF, "R3");
        drive(KV, N'($urandom), "R3");
        drive(KV ^ 13'h0100, KV ^ 13'h0100, "R3");

        // R5 / R6: single-bit differences at the edges.
        x = N'($urandom);
        drive(x, x ^ N'(1), "R5");
        drive(KV ^ N'(1), KV, "R5");
        drive(x, x ^ (N'(1) << (N - 1)), "R6");
        drive(KV ^ (N'(1) << (N - 1)), KV, "R6");

        // R7: bit 12 is the lone bit of the trailing chunk in every copy.
        drive(13'h1000, 13'h0000, "R7");
        drive(13'h1000, 13'h1000, "R7");
        drive(13'h0FFF, 13'h0FFF, "R7");
        drive(13'h0FFF, 13'h1FFF, "R7");

        // R8: a single differing bit walked through every position.
        for (int i = 0; i < int'(N); i++) begin
            x = N'($urandom);
            drive(x, x ^ (N'(1) << i), "R8");
            drive(KV ^ (N'(1) << i), x, "R8");
        end

        // R1 / R2: random mix of equal, unequal and constant-valued operands.
        for (int i = 0; i < 200; i++) begin
            x = N'($urandom);
            case (i % 4)
                0: drive(x, x, "R1");
                1: drive(x, N'($urandom), "R1");
                2: drive(KV, x, "R2");
                default: drive(x, x ^ N'($urandom_range(1, 8191)), "R1");
            endcase
        end

        while (q.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL R8 watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule